// File: doc/BRIEF.md
# Content-Aware Pixel Dispatch Scheduler

This block sits at the front of a parallel lossless image compressor. Each cycle it takes a batch of N pixels. For each pixel it receives the four causal neighbours (left, up, up-left, up-right) and a 10-bit context index that an upstream stage has already computed. It sums the absolute differences between neighbours to measure local texture, then compares that sum with a run-time threshold. The result marks the pixel as background noise or as structure.

Noise pixels are spread over a small pool of background cores by a fixed lane-based rotation. Structure pixels are hashed to a processing group by folding the two halves of the context index together with XOR. Inside a group, each distinct context gets its own encoder slot. A later pixel whose context is already in flight is held back in a wait queue. It is then issued one cycle at a time, so that per-context updates stay in raster order. When the queue cannot take another full batch, the block withdraws its ready signal and stalls upstream until the queue drains.

Every issued pixel leaves with a core number, its noise/structure bit and a sequence tag. A downstream reorder stage can use the tag to restore raster order.

Top module: `pixel_dispatch`

## Requirements
- R1: A lane's mask bit is 1 (structure) exactly when |up-right − up| + |up − up-left| + |up-left − left|, summed unsigned without overflow, is greater than or equal to the `threshold` input sampled in the accepting cycle; otherwise it is 0 (noise).
- R2: A noise lane at lane index l is issued to core number l mod NBG.
- R3: A structure lane is issued to core number NBG + g·N + s, where the group g is (ctx[4:0] XOR ctx[9:5]) mod NGROUPS and s is its encoder slot.
- R4: Among the structure lanes of a batch, a lane whose context differs from all lower lanes gets slot s equal to the number of lower such first-occurrence lanes in the same group. A lane repeating a lower lane's context inherits that lane's slot.
- R5: A structure lane whose context equals that of a lower-numbered structure lane in the same batch is not issued on its lane. It goes to the wait queue. The lowest such lane issues at once.
- R6: The wait queue issues at most one pixel per cycle on the queue port, in first-in first-out order. The queue port is valid in every cycle after a cycle in which the queue held an entry. Each queued pixel carries the core number and tag computed when its batch was accepted, so it runs on the same encoder as its earlier same-context pixel.
- R7: A new structure lane whose context matches any pixel held in the wait queue (including one leaving it in that cycle) is also queued, behind it.
- R8: `in_ready` is low and `stall` high whenever the queue holds more than DEPTH − N pixels. No batch is accepted then, and no accepted pixel is ever dropped: every accepted lane is eventually issued once, on its lane or on the queue port.
- R9: The tag of lane l in the k-th accepted batch since reset (k from 0) is (k·N + l) mod 2^TW.
- R10: After reset no lane or queue output is valid, `in_ready` is high and the batch count is zero.
- R11: A batch accepted at a clock edge (in_valid and in_ready high) shows its directly issued lanes on the lane outputs in the cycle that follows that edge only; without acceptance all lane valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Batch of N pixels present |
| in_ready | output | 1 | Block can accept a batch this cycle |
| stall | output | 1 | Upstream back-pressure, inverse of in_ready |
| pix_left | input | N·PW | Left neighbour per lane |
| pix_up | input | N·PW | Upper neighbour per lane |
| pix_upleft | input | N·PW | Upper-left neighbour per lane |
| pix_upright | input | N·PW | Upper-right neighbour per lane |
| ctx_idx | input | N·10 | Precomputed context index per lane |
| threshold | input | PW+2 | Noise threshold (gain times sensor sigma), may change at run time |
| lane_valid | output | N | Lane issued this cycle |
| lane_core | output | N·CW | Target core per lane |
| lane_mask | output | N | 1 structure, 0 noise |
| lane_tag | output | N·TW | Sequence tag per lane |
| q_valid | output | 1 | Wait-queue pixel issued this cycle |
| q_core | output | CW | Target core of the queued pixel |
| q_tag | output | TW | Sequence tag of the queued pixel |

## Verification
The embedded assertions watch invariants on every cycle. A noise lane never lands outside the background pool. Two issued structure lanes never share an encoder. A non-empty queue always issues on the next cycle. The queue never exceeds its depth and never grows while stalled, and the controller's occupancy always equals the number of live queue slots. Other properties need known stimulus and only the bench scenarios can show them. These are the exact threshold boundary, the slot ranking inside a group, the XOR-folded group choice, first-in first-out order across queue-matching batches, and the guarantee that every accepted pixel is issued exactly once. The bench checks them with a cycle-level model of the requirements over a threshold sweep, a same-context flood that forces a stall, crafted same-group batches and a long mixed run.

// File: rtl/disp_pkg.sv
package disp_pkg;

  localparam int CTX_W = 10;

  typedef struct packed {
    logic accept;
    logic pop;
  } disp_strobe_t;

  function automatic logic [4:0] foldCtx(input logic [CTX_W-1:0] ctx);
    return ctx[4:0] ^ ctx[9:5];
  endfunction

endpackage

// File: rtl/disp_control.sv
module disp_control
  import disp_pkg::*;
#(
  parameter int N     = 4,
  parameter int DEPTH = 8,
  localparam int OFS_W = $clog2(N + 1),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OFS_W-1:0] pushCount,
  output disp_strobe_t     strobe,
  output logic             inReady,
  output logic [CNT_W-1:0] occupancy
);

  logic stallNow;
  logic [CNT_W-1:0] occNext;

  assign stallNow = int'(occupancy) > (DEPTH - N);
  assign inReady  = !stallNow;

  always_comb begin
    strobe.accept = inValid && !stallNow;
    strobe.pop    = (occupancy != '0);
    occNext = occupancy
            + (strobe.accept ? CNT_W'(pushCount) : CNT_W'(0))
            - (strobe.pop ? CNT_W'(1) : CNT_W'(0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occupancy <= '0;
    else       occupancy <= occNext;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    int'(occupancy) <= DEPTH); // R8

  AST_STALL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
    stallNow |=> occupancy <= $past(occupancy)); // R8

endmodule

// File: rtl/disp_datapath.sv
module disp_datapath
  import disp_pkg::*;
#(
  parameter int N       = 4,
  parameter int PW      = 12,
  parameter int NBG     = 2,
  parameter int NGROUPS = 8,
  parameter int DEPTH   = 8,
  parameter int TW      = 8,
  parameter int CW      = 6,
  localparam int OFS_W  = $clog2(N + 1),
  localparam int GW     = (NGROUPS > 1) ? $clog2(NGROUPS) : 1,
  localparam int SW     = (N > 1) ? $clog2(N) : 1,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SUM_W  = PW + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  disp_strobe_t       strobe,
  input  logic [N*PW-1:0]    pixLeft,
  input  logic [N*PW-1:0]    pixUp,
  input  logic [N*PW-1:0]    pixUpLeft,
  input  logic [N*PW-1:0]    pixUpRight,
  input  logic [N*CTX_W-1:0] ctxIdx,
  input  logic [SUM_W-1:0]   threshold,
  output logic [OFS_W-1:0]   pushCount,
  output logic [DEPTH-1:0]   entryValid,
  output logic [N-1:0]       laneValid,
  output logic [N*CW-1:0]    laneCore,
  output logic [N-1:0]       laneMask,
  output logic [N*TW-1:0]    laneTag,
  output logic               qValid,
  output logic [CW-1:0]      qCore,
  output logic [TW-1:0]      qTag
);

  function automatic logic [PW-1:0] absDiff(input logic [PW-1:0] x, input logic [PW-1:0] y);
    return (x > y) ? (x - y) : (y - x);
  endfunction

  logic [PW-1:0]    pa [N];
  logic [PW-1:0]    pb [N];
  logic [PW-1:0]    pc [N];
  logic [PW-1:0]    pd [N];
  logic [CTX_W-1:0] ctx [N];
  logic [SUM_W-1:0] texture [N];
  logic [GW-1:0]    grp [N];
  logic [N-1:0]     isStruct;
  logic [N-1:0]     dupEarlier;
  logic [N-1:0]     qHit;
  logic [N-1:0]     toQueue;
  logic [SW-1:0]    slot [N];
  logic [OFS_W-1:0] pushOfs [N];
  logic [PTR_W-1:0] pushIdx [N];
  logic [CW-1:0]    core [N];
  logic [TW-1:0]    tag [N];

  // queue storage and pointers
  logic [CTX_W-1:0] entCtx [DEPTH];
  logic [CW-1:0]    entCore [DEPTH];
  logic [TW-1:0]    entTag [DEPTH];
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtr;
  logic [TW-1:0]    batchCnt;

  logic [CW-1:0]    laneCoreR [N];
  logic [TW-1:0]    laneTagR [N];

  // per-lane unpack, texture measure and hash
  for (genvar l = 0; l < N; l++) begin : g_lane
    assign pa[l]  = pixLeft[l*PW +: PW];
    assign pb[l]  = pixUp[l*PW +: PW];
    assign pc[l]  = pixUpLeft[l*PW +: PW];
    assign pd[l]  = pixUpRight[l*PW +: PW];
    assign ctx[l] = ctxIdx[l*CTX_W +: CTX_W];
    assign texture[l] = SUM_W'(absDiff(pd[l], pb[l]))
                      + SUM_W'(absDiff(pb[l], pc[l]))
                      + SUM_W'(absDiff(pc[l], pa[l]));
    assign isStruct[l] = (texture[l] >= threshold);
    assign grp[l] = GW'(int'(foldCtx(ctx[l])) % NGROUPS);
    assign core[l] = isStruct[l]
                   ? CW'(NBG + int'(grp[l]) * N + int'(slot[l]))
                   : CW'(l % NBG);
    assign tag[l] = TW'(int'(batchCnt) * N + l);
    assign pushIdx[l] = wrPtr + PTR_W'(pushOfs[l]);
    assign laneCore[l*CW +: CW] = laneCoreR[l];
    assign laneTag[l*TW +: TW]  = laneTagR[l];
  end

  // pairwise context comparison, slot ranking, queue hits
  always_comb begin
    logic found;
    logic [SW-1:0] firstSlot;
    logic [SW-1:0] rank;
    logic hit;
    logic [OFS_W-1:0] run;
    run = '0;
    for (int l = 0; l < N; l++) begin
      found = 1'b0;
      firstSlot = '0;
      rank = '0;
      hit = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (i < l && isStruct[i] && !found && ctx[i] == ctx[l]) begin
          found = 1'b1;
          firstSlot = slot[i];
        end
      end
      for (int i = 0; i < N; i++) begin
        if (i < l && isStruct[i] && !dupEarlier[i] && grp[i] == grp[l])
          rank = SW'(rank + 1'b1);
      end
      for (int e = 0; e < DEPTH; e++) begin
        if (entryValid[e] && entCtx[e] == ctx[l]) hit = 1'b1;
      end
      dupEarlier[l] = isStruct[l] && found;
      slot[l]       = found ? firstSlot : rank;
      qHit[l]       = isStruct[l] && hit;
      toQueue[l]    = isStruct[l] && (found || hit);
      pushOfs[l]    = run;
      run = run + OFS_W'(toQueue[l]);
    end
    pushCount = run;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneValid  <= '0;
      laneMask   <= '0;
      qValid     <= 1'b0;
      qCore      <= '0;
      qTag       <= '0;
      rdPtr      <= '0;
      wrPtr      <= '0;
      batchCnt   <= '0;
      entryValid <= '0;
      for (int l = 0; l < N; l++) begin
        laneCoreR[l] <= '0;
        laneTagR[l]  <= '0;
      end
      for (int e = 0; e < DEPTH; e++) begin
        entCtx[e]  <= '0;
        entCore[e] <= '0;
        entTag[e]  <= '0;
      end
    end else begin
      laneValid <= strobe.accept ? ~toQueue : '0;
      qValid    <= strobe.pop;
      if (strobe.pop) begin
        qCore             <= entCore[rdPtr];
        qTag              <= entTag[rdPtr];
        entryValid[rdPtr] <= 1'b0;
        rdPtr             <= rdPtr + 1'b1;
      end
      if (strobe.accept) begin
        laneMask <= isStruct;
        for (int l = 0; l < N; l++) begin
          laneCoreR[l] <= core[l];
          laneTagR[l]  <= tag[l];
          if (toQueue[l]) begin
            entCtx[pushIdx[l]]     <= ctx[l];
            entCore[pushIdx[l]]    <= core[l];
            entTag[pushIdx[l]]     <= tag[l];
            entryValid[pushIdx[l]] <= 1'b1;
          end
        end
        wrPtr    <= wrPtr + PTR_W'(pushCount);
        batchCnt <= batchCnt + 1'b1;
      end
    end
  end

  for (genvar l = 0; l < N; l++) begin : g_chk
    AST_NOISE_IN_POOL: assert property (@(posedge clk) disable iff (!rstN)
      (laneValid[l] && !laneMask[l]) |-> int'(laneCoreR[l]) < NBG); // R2
    for (genvar m = l + 1; m < N; m++) begin : g_pair
      AST_DISTINCT_ENCODERS: assert property (@(posedge clk) disable iff (!rstN)
        (laneValid[l] && laneValid[m] && laneMask[l] && laneMask[m])
          |-> laneCoreR[l] != laneCoreR[m]); // R5
    end
  end

  AST_QUEUE_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    (|entryValid) |=> qValid); // R6

endmodule

// File: rtl/pixel_dispatch.sv
module pixel_dispatch
  import disp_pkg::*;
#(
  parameter int N       = 4,
  parameter int PW      = 12,
  parameter int NBG     = 2,
  parameter int NGROUPS = 8,
  parameter int DEPTH   = 8,
  parameter int TW      = 8,
  localparam int CW     = $clog2(NBG + NGROUPS * N),
  localparam int OFS_W  = $clog2(N + 1),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  output logic               stall,
  input  logic [N*PW-1:0]    pix_left,
  input  logic [N*PW-1:0]    pix_up,
  input  logic [N*PW-1:0]    pix_upleft,
  input  logic [N*PW-1:0]    pix_upright,
  input  logic [N*CTX_W-1:0] ctx_idx,
  input  logic [PW+1:0]      threshold,
  output logic [N-1:0]       lane_valid,
  output logic [N*CW-1:0]    lane_core,
  output logic [N-1:0]       lane_mask,
  output logic [N*TW-1:0]    lane_tag,
  output logic               q_valid,
  output logic [CW-1:0]      q_core,
  output logic [TW-1:0]      q_tag
);

  disp_strobe_t     strobe;
  logic [OFS_W-1:0] pushCount;
  logic [CNT_W-1:0] occupancy;
  logic [DEPTH-1:0] entryValid;

  disp_control #(.N(N), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rst_n), .inValid(in_valid), .pushCount(pushCount),
    .strobe(strobe), .inReady(in_ready), .occupancy(occupancy)
  );

  disp_datapath #(
    .N(N), .PW(PW), .NBG(NBG), .NGROUPS(NGROUPS), .DEPTH(DEPTH), .TW(TW), .CW(CW)
  ) u_dp (
    .clk(clk), .rstN(rst_n), .strobe(strobe),
    .pixLeft(pix_left), .pixUp(pix_up), .pixUpLeft(pix_upleft), .pixUpRight(pix_upright),
    .ctxIdx(ctx_idx), .threshold(threshold),
    .pushCount(pushCount), .entryValid(entryValid),
    .laneValid(lane_valid), .laneCore(lane_core), .laneMask(lane_mask), .laneTag(lane_tag),
    .qValid(q_valid), .qCore(q_core), .qTag(q_tag)
  );

  assign stall = !in_ready;

  AST_OCCUPANCY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(entryValid) == int'(occupancy)); // R8

endmodule

// File: tb/sim_pixel_dispatch.sv
`timescale 1ns/1ps
module sim_pixel_dispatch;

  localparam int N = 4, PW = 6, NBG = 3, NGROUPS = 4, DEPTH = 8, TW = 6;
  localparam int CW = $clog2(NBG + NGROUPS * N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, stall;
  logic [N*PW-1:0] pix_left = '0, pix_up = '0, pix_upleft = '0, pix_upright = '0;
  logic [N*10-1:0] ctx_idx = '0;
  logic [PW+1:0] threshold = '0;
  logic [N-1:0] lane_valid, lane_mask;
  logic [N*CW-1:0] lane_core;
  logic [N*TW-1:0] lane_tag;
  logic q_valid;
  logic [CW-1:0] q_core;
  logic [TW-1:0] q_tag;

  always #2 clk = ~clk;

  pixel_dispatch #(.N(N), .PW(PW), .NBG(NBG), .NGROUPS(NGROUPS), .DEPTH(DEPTH), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .stall(stall),
    .pix_left(pix_left), .pix_up(pix_up), .pix_upleft(pix_upleft), .pix_upright(pix_upright),
    .ctx_idx(ctx_idx), .threshold(threshold),
    .lane_valid(lane_valid), .lane_core(lane_core), .lane_mask(lane_mask), .lane_tag(lane_tag),
    .q_valid(q_valid), .q_core(q_core), .q_tag(q_tag)
  );

  int checks = 0, errors = 0;
  // stimulus
  int sa[N], sb[N], sc[N], sd[N], sq[N];
  int sThr = 0;
  bit sValid = 0;
  // model state
  int mqCtx[DEPTH], mqCore[DEPTH], mqTag[DEPTH];
  int mCount = 0, batch = 0;
  bit expLV[N];
  int expCore[N], expMask[N], expTag[N], expSlot[N], expWhy[N];
  bit expQV = 0;
  int expQCore = 0, expQTag = 0;
  int accLanes = 0, seenIssued = 0;
  int unsigned rs = 32'h1234_5678;

  function automatic int unsigned rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  function automatic int ad(input int x, input int y);
    return (x > y) ? x - y : y - x;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doCycle();
    int sum[N]; bit st[N]; int grp[N]; bit dup[N]; bit hit[N]; int slot[N];
    bit ready, accept;
    // compare outputs against the expectation for this cycle
    for (int l = 0; l < N; l++) begin
      string r;
      r = (expWhy[l] == 1) ? "R5" : (expWhy[l] == 2) ? "R7" : "R11";
      check(lane_valid[l] === expLV[l], r, $sformatf("lane%0d valid", l), int'(lane_valid[l]), int'(expLV[l]));
      if (lane_valid[l] === 1'b1) seenIssued++;
      if (expLV[l]) begin
        check(lane_mask[l] === expMask[l][0], "R1", $sformatf("lane%0d mask", l), int'(lane_mask[l]), expMask[l]);
        check(int'(lane_core[l*CW +: CW]) == expCore[l],
              (expMask[l] == 0) ? "R2" : (expSlot[l] > 0) ? "R4" : "R3",
              $sformatf("lane%0d core", l), int'(lane_core[l*CW +: CW]), expCore[l]);
        check(int'(lane_tag[l*TW +: TW]) == expTag[l], "R9", $sformatf("lane%0d tag", l),
              int'(lane_tag[l*TW +: TW]), expTag[l]);
      end
    end
    check(q_valid === expQV, "R6", "queue valid", int'(q_valid), int'(expQV));
    if (q_valid === 1'b1) seenIssued++;
    if (expQV) begin
      check(int'(q_core) == expQCore, "R6", "queue core", int'(q_core), expQCore);
      check(int'(q_tag) == expQTag, "R6", "queue tag", int'(q_tag), expQTag);
    end
    // back-pressure at current occupancy
    ready = (mCount <= DEPTH - N);
    check(in_ready === ready, "R8", "in_ready", int'(in_ready), int'(ready));
    check(stall === !ready, "R8", "stall", int'(stall), int'(!ready));
    accept = sValid && ready;
    // classification against the pre-pop queue
    for (int l = 0; l < N; l++) begin
      sum[l] = ad(sd[l], sb[l]) + ad(sb[l], sc[l]) + ad(sc[l], sa[l]);
      st[l]  = (sum[l] >= sThr);
      grp[l] = ((sq[l] & 31) ^ ((sq[l] >> 5) & 31)) % NGROUPS;
      dup[l] = 0; slot[l] = 0; hit[l] = 0;
      if (st[l]) begin
        for (int i = 0; i < l; i++)
          if (!dup[l] && st[i] && sq[i] == sq[l]) begin dup[l] = 1; slot[l] = slot[i]; end
        if (!dup[l])
          for (int i = 0; i < l; i++)
            if (st[i] && !dup[i] && grp[i] == grp[l]) slot[l]++;
        for (int e = 0; e < mCount; e++) if (mqCtx[e] == sq[l]) hit[l] = 1;
      end
    end
    // pop head
    expQV = (mCount > 0);
    if (expQV) begin
      expQCore = mqCore[0]; expQTag = mqTag[0];
      for (int e = 0; e < DEPTH - 1; e++) begin
        mqCtx[e] = mqCtx[e+1]; mqCore[e] = mqCore[e+1]; mqTag[e] = mqTag[e+1];
      end
      mCount--;
    end
    // lanes and pushes
    for (int l = 0; l < N; l++) begin
      expMask[l] = st[l];
      expSlot[l] = slot[l];
      expCore[l] = st[l] ? NBG + grp[l] * N + slot[l] : l % NBG;
      expTag[l]  = (batch * N + l) % (1 << TW);
      expWhy[l]  = !accept ? 0 : dup[l] ? 1 : hit[l] ? 2 : 0;
      expLV[l]   = accept && !dup[l] && !hit[l];
      if (accept && (dup[l] || hit[l])) begin
        mqCtx[mCount] = sq[l]; mqCore[mCount] = expCore[l]; mqTag[mCount] = expTag[l];
        mCount++;
      end
    end
    if (accept) begin batch++; accLanes += N; end
    // drive
    in_valid = sValid;
    threshold = sThr[PW+1:0];
    for (int l = 0; l < N; l++) begin
      pix_left[l*PW +: PW]    = sa[l][PW-1:0];
      pix_up[l*PW +: PW]      = sb[l][PW-1:0];
      pix_upleft[l*PW +: PW]  = sc[l][PW-1:0];
      pix_upright[l*PW +: PW] = sd[l][PW-1:0];
      ctx_idx[l*10 +: 10]     = sq[l][9:0];
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic randLanes(input int ctxMode);
    for (int l = 0; l < N; l++) begin
      sa[l] = rnd() % 64; sb[l] = rnd() % 64; sc[l] = rnd() % 64; sd[l] = rnd() % 64;
      if (ctxMode == 0) sq[l] = rnd() % 1024;
      else sq[l] = (rnd() % 6) | ((rnd() % 2) << 5);
    end
  endtask

  task automatic setFlat(input int l, input int q);
    sa[l] = 0; sb[l] = 0; sc[l] = 0; sd[l] = 0; sq[l] = q;
  endtask

  initial begin
    for (int l = 0; l < N; l++) begin
      sa[l] = 0; sb[l] = 0; sc[l] = 0; sd[l] = 0; sq[l] = 0;
      expLV[l] = 0; expCore[l] = 0; expMask[l] = 0; expTag[l] = 0; expSlot[l] = 0; expWhy[l] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    check(lane_valid === '0, "R10", "lane valid after reset", int'(lane_valid), 0);
    check(q_valid === 1'b0, "R10", "queue valid after reset", int'(q_valid), 0);
    check(in_ready === 1'b1, "R10", "in_ready after reset", int'(in_ready), 1);

    // threshold sweep with exact-boundary lanes (R1); first batch carries tag 0 (R10)
    for (int t = 0; t < 256; t++) begin
      randLanes(0);
      sThr = t; sValid = 1;
      sa[0] = 63; sb[0] = 63; sc[0] = 0; sd[0] = 0;          // sum 189
      if (t <= 63) begin
        setFlat(1, 100 + t); sd[1] = t;                      // sum == t
        setFlat(2, 200 + t); sd[2] = (t > 0) ? t - 1 : 0;    // sum t-1
      end
      doCycle();
    end

    // same-context flood: all structure, one context, forces back-pressure (R5, R8)
    sThr = 0;
    for (int c = 0; c < 10; c++) begin
      for (int l = 0; l < N; l++) setFlat(l, 5);
      sValid = 1;
      doCycle();
    end
    sValid = 0;
    repeat (12) doCycle();

    // same group, distinct and repeated contexts (R3, R4)
    for (int p = 0; p < 6; p++) begin
      sValid = 1; sThr = 0;
      setFlat(0, 0); setFlat(1, 4 + p % 2 * 33); setFlat(2, 8); setFlat(3, (p > 2) ? 4 : 12);
      doCycle();
      sValid = 0;
      repeat (3) doCycle();
    end
    // a context matching the queue head keeps behind it (R7)
    sValid = 1; sThr = 0;
    for (int l = 0; l < N; l++) setFlat(l, 9);
    doCycle();
    setFlat(0, 9); setFlat(1, 300); setFlat(2, 301); setFlat(3, 9);
    doCycle();
    sValid = 0;
    repeat (6) doCycle();

    // long mixed run with small context alphabet
    for (int c = 0; c < 500; c++) begin
      randLanes(1);
      sThr = rnd() % 150;
      sValid = (rnd() % 4) != 0;
      doCycle();
    end
    sValid = 0;
    repeat (12) doCycle();

    // R8: nothing dropped, nothing duplicated
    check(seenIssued == accLanes, "R8", "issued vs accepted lanes", seenIssued, accLanes);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule